// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small word-addressed memory and serves several requesters through one shared port. Each requester offers a request with a valid/ready pair. The request carries a 2-bit operation code, an address, a data operand and a compare operand. Besides plain loads and stores, the unit performs two indivisible operations. Test-and-set takes a lock word. Compare-and-swap replaces a word only when the word still holds the value the requester expects. Software builds spin locks and lock-free queue updates on top of these two operations.

A round-robin arbiter accepts at most one request per cycle. Loads and stores complete in one internal cycle. An atomic operation reads the word in its first cycle and writes it conditionally in its second. The arbiter accepts nothing else during that second cycle, so no other access can fall between the read and the write. Every response returns to the requester that issued the request. It carries the word as it was before the operation, plus a success bit.

Top module: `atomic_mem`

## Requirements
- R1: A load (opcode 00) returns the addressed word with the success bit set, and leaves memory unchanged.
- R2: A store (opcode 01) writes the data operand to the addressed word. Its response returns the previous value of the word with the success bit set. A store of 0 to a lock word frees the lock.
- R3: Test-and-set (opcode 10) on a word that reads 0 writes 1 to it, returns 0 and reports success.
- R4: Test-and-set on a nonzero word leaves the word unchanged, returns its value and reports failure.
- R5: Compare-and-swap (opcode 11) whose compare operand equals the word writes the data operand to it, returns the old word (equal to the compare operand) and reports success.
- R6: Compare-and-swap whose compare operand differs from the word leaves the word unchanged, returns its value and reports failure.
- R7: In the cycle after an atomic request is accepted, no request of any requester is accepted. When two requesters run atomic operations on the same word, exactly one of them succeeds.
- R8: At most one ready bit is high in any cycle. When every requester is waiting, grants rotate in increasing index order, starting after the last requester served.
- R9: A load or store response appears the cycle after acceptance, and an atomic response two cycles after acceptance. Exactly one response-valid bit is raised, the one of the issuing requester.
- R10: After reset, every memory word is 0, no response is valid, and no ready bit is high while no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_ready | output | NREQ | Request accepted this cycle, one-hot or zero |
| req_op | input | 2*NREQ | Operation code per requester: 00 load, 01 store, 10 test-and-set, 11 compare-and-swap |
| req_addr | input | AW*NREQ | Word address per requester |
| req_data | input | DW*NREQ | Store data or swap value per requester |
| req_cmp | input | DW*NREQ | Compare operand for compare-and-swap, per requester |
| rsp_valid | output | NREQ | Response pulse, one-hot on the issuing requester |
| rsp_data | output | DW | Word value before the operation |
| rsp_ok | output | 1 | Success bit; 1 for loads and stores |

## Verification
The main function runs through a vector walk. A test-and-set on a free word and on a held word shows that the write depends on the value read. A lock release by a plain store followed by a fresh test-and-set confirms the release. Compare-and-swap runs once with a matching compare operand and once with a stale one, and a load afterwards shows whether memory moved. An all-ones word shows that a nonzero test is a full-width test. Requests from all four requesters at once show the rotation of the grants. Two concurrent compare-and-swaps on one word, and a load that arrives while a test-and-set is in its write cycle, show that the atomic pair is indivisible.

// File: rtl/atomic_mem.sv
module atomic_mem #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_valid,
  output logic [NREQ-1:0]   req_ready,
  input  logic [2*NREQ-1:0] req_op,
  input  logic [AW*NREQ-1:0] req_addr,
  input  logic [DW*NREQ-1:0] req_data,
  input  logic [DW*NREQ-1:0] req_cmp,
  output logic [NREQ-1:0]   rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic              rsp_ok
);
  localparam int IW    = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OP_ST  = 2'b01;
  localparam logic [1:0] OP_TAS = 2'b10;

  logic [DW-1:0]   mem [DEPTH];
  logic [IW-1:0]   rr_q, gnt, id_q;
  logic            gnt_hit, busy_q, acc, acc_atom;
  logic [1:0]      sel_op, op_q;
  logic [AW-1:0]   sel_addr, addr_q;
  logic [DW-1:0]   sel_data, sel_cmp, rd_word;
  logic [DW-1:0]   old_q, new_q, cmp_q, wval;
  logic            hit;
  logic [NREQ-1:0] rsp_valid_q;
  logic [DW-1:0]   rsp_data_q;
  logic            rsp_ok_q;

  always_comb begin
    gnt     = '0;
    gnt_hit = 1'b0;
    for (int k = 1; k <= NREQ; k++) begin
      int idx;
      idx = (int'(rr_q) + k) % NREQ;
      if (!gnt_hit && req_valid[idx]) begin
        gnt_hit = 1'b1;
        gnt     = IW'(idx);
      end
    end
  end

  assign acc       = gnt_hit && !busy_q;
  assign req_ready = acc ? (NREQ'(1) << gnt) : '0;
  assign sel_op    = req_op[2*gnt +: 2];
  assign sel_addr  = req_addr[AW*gnt +: AW];
  assign sel_data  = req_data[DW*gnt +: DW];
  assign sel_cmp   = req_cmp[DW*gnt +: DW];
  assign rd_word   = mem[sel_addr];
  assign acc_atom  = acc && sel_op[1];

  assign hit  = (op_q == OP_TAS) ? (old_q == '0) : (old_q == cmp_q);
  assign wval = (op_q == OP_TAS) ? DW'(1) : new_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rr_q        <= IW'(NREQ - 1);
      busy_q      <= 1'b0;
      id_q        <= '0;
      op_q        <= '0;
      addr_q      <= '0;
      old_q       <= '0;
      new_q       <= '0;
      cmp_q       <= '0;
      rsp_valid_q <= '0;
      rsp_data_q  <= '0;
      rsp_ok_q    <= 1'b0;
    end else if (busy_q) begin
      if (hit) mem[addr_q] <= wval;
      busy_q      <= 1'b0;
      rsp_valid_q <= NREQ'(1) << id_q;
      rsp_data_q  <= old_q;
      rsp_ok_q    <= hit;
    end else begin
      rsp_valid_q <= '0;
      if (acc) begin
        rr_q   <= gnt;
        id_q   <= gnt;
        op_q   <= sel_op;
        addr_q <= sel_addr;
        old_q  <= rd_word;
        new_q  <= sel_data;
        cmp_q  <= sel_cmp;
        if (sel_op == OP_ST) mem[sel_addr] <= sel_data;
        if (sel_op[1]) begin
          busy_q <= 1'b1;
        end else begin
          rsp_valid_q <= NREQ'(1) << gnt;
          rsp_data_q  <= rd_word;
          rsp_ok_q    <= 1'b1;
        end
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_ok    = rsp_ok_q;
endmodule

module atomic_mem_chk #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] req_ready,
  input logic [NREQ-1:0] rsp_valid,
  input logic            rsp_ok,
  input logic            acc_atom
);
  logic acc;
  assign acc = |(req_valid & req_ready);

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  // R8
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // R9
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  // R7
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && acc_atom) |=> (req_ready == '0));

  // R9
  fast_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_atom) |=> (rsp_valid != '0));

  // R9
  slow_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && acc_atom) |=> (rsp_valid == '0));

  // R4
  fail_only_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0 && !rsp_ok) |-> $past(acc && acc_atom, 2));
endmodule

bind atomic_mem atomic_mem_chk #(.NREQ(NREQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ok    (rsp_ok),
  .acc_atom  (acc_atom)
);

// File: tb/sim_atomic_mem.sv
`timescale 1ns/1ps
module sim_atomic_mem;
  localparam int N = 4, AW = 4, DW = 16, NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_ready;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_data = '0;
  logic [DW*N-1:0] req_cmp = '0;
  logic [N-1:0]    rsp_valid;
  logic [DW-1:0]   rsp_data;
  logic            rsp_ok;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  atomic_mem #(.NREQ(N), .AW(AW), .DW(DW)) u0 (.*);

  // {op, id, addr, data, cmp, expected data, expected ok, requirement}
  localparam logic [60:0] VEC [NV] = '{
    {2'd0, 2'd0, 4'h3, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd10},
    {2'd1, 2'd1, 4'h3, 16'h1234, 16'h0000, 16'h0000, 1'b1, 4'd2},
    {2'd0, 2'd2, 4'h3, 16'h0000, 16'h0000, 16'h1234, 1'b1, 4'd1},
    {2'd2, 2'd3, 4'h5, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd3},
    {2'd0, 2'd0, 4'h5, 16'h0000, 16'h0000, 16'h0001, 1'b1, 4'd3},
    {2'd2, 2'd1, 4'h5, 16'h0000, 16'h0000, 16'h0001, 1'b0, 4'd4},
    {2'd0, 2'd2, 4'h5, 16'h0000, 16'h0000, 16'h0001, 1'b1, 4'd4},
    {2'd1, 2'd3, 4'h5, 16'h0000, 16'h0000, 16'h0001, 1'b1, 4'd2},
    {2'd2, 2'd0, 4'h5, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd3},
    {2'd3, 2'd1, 4'h3, 16'h00AB, 16'h1234, 16'h1234, 1'b1, 4'd5},
    {2'd0, 2'd2, 4'h3, 16'h0000, 16'h0000, 16'h00AB, 1'b1, 4'd5},
    {2'd3, 2'd3, 4'h3, 16'h5555, 16'h1234, 16'h00AB, 1'b0, 4'd6},
    {2'd0, 2'd0, 4'h3, 16'h0000, 16'h0000, 16'h00AB, 1'b1, 4'd6},
    {2'd1, 2'd1, 4'hF, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 4'd2},
    {2'd2, 2'd2, 4'hF, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 4'd4},
    {2'd0, 2'd3, 4'hF, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 4'd4}
  };

  function automatic string rq(int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic chk(bit good, string r, string what, int act, int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic run(int id, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                     logic [DW-1:0] c, output logic [DW-1:0] rd, output logic ok,
                     output int lat);
    @(negedge clk);
    req_op[2*id +: 2]     = op;
    req_addr[AW*id +: AW] = a;
    req_data[DW*id +: DW] = d;
    req_cmp[DW*id +: DW]  = c;
    req_valid[id]         = 1'b1;
    #1;
    while (!req_ready[id]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid[id] = 1'b0;
    lat = 1;
    while (!rsp_valid[id] && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_data;
    ok = rsp_ok;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd, rd2;
    logic ok, ok2;
    int lat, lat2, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == '0, "R10", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == '0, "R10", "req_ready idle", req_ready, 0);

    for (int v = 0; v < NV; v++) begin
      logic [60:0] e;
      e = VEC[v];
      run(int'(e[58:57]), e[60:59], e[56:53], e[52:37], e[36:21], rd, ok, lat);
      chk(rd == e[20:5], rq(int'(e[3:0])), $sformatf("vec %0d data", v), rd, e[20:5]);
      chk(ok == e[4], rq(int'(e[3:0])), $sformatf("vec %0d ok", v), ok, e[4]);
      chk(lat == (e[60] ? 2 : 1), "R9", $sformatf("vec %0d latency", v), lat, e[60] ? 2 : 1);
    end

    // R8: all requesters waiting; last served was 3, so order is 0,1,2,3
    @(negedge clk);
    req_op = '0;
    req_valid = '1;
    prev = 3;
    for (int i = 0; i < N; i++) begin
      int g;
      #1;
      g = -1;
      for (int j = 0; j < N; j++) if (req_ready[j]) g = j;
      chk($onehot(req_ready), "R8", "single grant", req_ready, 1 << ((prev + 1) % N));
      chk(g == (prev + 1) % N, "R8", "rotation", g, (prev + 1) % N);
      prev = g;
      @(posedge clk);
      @(negedge clk);
      if (g >= 0) req_valid[g] = 1'b0;
    end
    req_valid = '0;
    repeat (2) @(negedge clk);

    // R7: test-and-set on word 7, then a load arrives during the write cycle
    req_op[1:0] = 2'b10;
    req_addr[3:0] = 4'h7;
    req_valid[0] = 1'b1;
    #1;
    chk(req_ready[0] == 1'b1, "R7", "tas accepted", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid[0] = 1'b0;
    req_op[3:2] = 2'b00;
    req_addr[7:4] = 4'h7;
    req_valid[1] = 1'b1;
    #1;
    chk(req_ready == '0, "R7", "no grant in write cycle", req_ready, 0);
    @(negedge clk);
    #1;
    chk(req_ready == 4'b0010, "R7", "grant after write cycle", req_ready, 2);
    @(posedge clk);
    @(negedge clk);
    req_valid[1] = 1'b0;
    chk(rsp_valid == 4'b0010 && rsp_data == 16'h0001, "R7", "load sees tas write", rsp_data, 1);
    repeat (2) @(negedge clk);

    // R7: two compare-and-swaps race on word 9 expecting 0
    fork
      run(2, 2'b11, 4'h9, 16'h0102, 16'h0000, rd, ok, lat);
      run(3, 2'b11, 4'h9, 16'h0103, 16'h0000, rd2, ok2, lat2);
    join
    chk((ok ^ ok2) == 1'b1, "R7", "exactly one swap wins", {ok, ok2}, 2);
    run(0, 2'b00, 4'h9, 16'h0, 16'h0, rd, ok, lat);
    chk(rd == (ok2 ? 16'h0103 : 16'h0102), "R5", "winner value stored", rd, ok2 ? 16'h0103 : 16'h0102);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule